// File: doc/BRIEF.md
# Eight-Channel Converter Register Control

This block is the digital front end of an eight-channel voltage-output converter. A host sends 32-bit command frames over a three-wire serial port (active-low frame select `sync_n`, serial clock `sclk`, data `sdi`). Each channel holds two register levels. A staging level receives new codes. An active level drives the converter code output. A command can write a staging level, copy it to the active level, or do both at once.

Two pins move data into the active registers without the serial port. The load strobe `ld_n` is active low and sampled on the system clock. It copies staging into active for every channel enabled in a programmable mask. The clear input `clr_n` forces every output code to a programmable zero, mid or full scale value the moment it goes low. Its release is synchronized to `clk`. Each channel also has a two-bit power-down mode. There is a reference enable bit. A build parameter chooses whether reset leaves the codes at zero scale or at midscale.

Top module: `octdac_ctrl`

## Requirements
- R1: A frame is 32 bits, sent MSB first, with each bit taken on a falling `sclk` edge while `sync_n` is low. Frame bits 27:24 hold the command, bits 23:20 the address, and bits 19:4 a 16-bit data field. The channel code is the top W bits of that data field, so it is left-justified.
- R2: A frame takes effect only if `sync_n` rises after exactly 32 falling `sclk` edges. A frame of any other length changes no output.
- R3: Command 0 writes the staging register of the addressed channel and changes no output. Command 1 copies staging to active for the addressed channel. Address 15 selects all channels, and addresses 8 to 14 select none. While no frame executes, `ld_n` is high and clear is inactive, no output code changes.
- R4: Command 2 writes staging of the addressed channel, then copies staging to active on all eight channels. Command 3 writes both staging and active of the addressed channel only.
- R5: While `ld_n` is low at a `clk` edge, each channel whose mask bit is 1 copies staging to active. Command 6 loads the mask from data bits 7:0, where bit i is channel i. After reset the mask is all ones.
- R6: When `clr_n` goes low, every output code changes to the clear code without waiting for `clk`. Command 5 selects the clear code from data bits 1:0: 00 gives zero, 01 gives midscale (MSB only set), 10 gives full scale, and 11 gives zero. After reset the selection is 00.
- R7: While clear is in force, no write reaches an active register, but staging writes are kept. After release, the active codes equal the clear code.
- R8: Command 4 writes data bits 9:8 as the mode of each channel whose bit is set in data bits 7:0. The mode appears on `pd_o[2i+1:2i]`: 00 is normal, 01 is a 1 kΩ load, 10 is a 100 kΩ load, and 11 is three-state. The channel's active code is unchanged.
- R9: Command 8 sets `ref_en_o` to data bit 0. After reset it is 0.
- R10: After reset every code equals midscale when `RESET_MID` is 1 and zero otherwise. All power-down modes are 00. The codes hold until a write moves them.
- R11: Command 7 returns staging, active, modes, mask, clear selection and reference enable to their reset values.
- R12: Commands 9 to 15 have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sync_n | input | 1 | Frame select, active low |
| sclk | input | 1 | Serial clock, data taken on falling edge |
| sdi | input | 1 | Serial data |
| ld_n | input | 1 | Load strobe, active low, synchronous to clk |
| clr_n | input | 1 | Asynchronous clear, active low |
| code_o | output | 8*W | Active codes, channel i at bits [i*W +: W] |
| pd_o | output | 16 | Power-down mode, two bits per channel |
| ref_en_o | output | 1 | Internal reference enable |

## Verification
Directed cases come first. They place single-channel, broadcast and invalid addresses against staging-only and staging-plus-active commands, which shows whether the two register levels are kept apart. Masked strobes show which channels the mask admits. Frames of 31 and 33 bits show that a wrong length is dropped, not partly applied. Clear is driven between clock edges, with the clear selection at each value and with writes sent while clear is held; this separates the immediate force from the synchronized release. A seeded random mix of commands, addresses, lengths and strobes then runs against a bench model.

// File: rtl/octdac_pkg.sv
package octdac_pkg;
  localparam int NCH        = 8;
  localparam int FRAME_BITS = 32;

  typedef enum logic [3:0] {
    CMD_WR_STG     = 4'd0,
    CMD_UPD_ACT    = 4'd1,
    CMD_WR_UPD_ALL = 4'd2,
    CMD_WR_UPD_ONE = 4'd3,
    CMD_PWR        = 4'd4,
    CMD_CLR_SEL    = 4'd5,
    CMD_LD_MASK    = 4'd6,
    CMD_RESET      = 4'd7,
    CMD_REF        = 4'd8
  } cmd_e;

  typedef struct packed {
    logic [3:0]  cmd;
    logic [3:0]  addr;
    logic [15:0] data;
  } frame_t;
endpackage

// File: rtl/octdac_sport.sv
module octdac_sport
  import octdac_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   sync_n,
  input  logic   sclk,
  input  logic   sdi,
  output logic   exec_o,
  output frame_t frame_o
);
  localparam int SHW = 28;
  localparam int CW  = $clog2(FRAME_BITS + 2);
  localparam logic [CW-1:0] CNT_FULL = CW'(FRAME_BITS);
  localparam logic [CW-1:0] CNT_SAT  = CW'(FRAME_BITS + 1);

  logic [SHW-1:0] sh_q;
  logic [CW-1:0]  cnt_q;
  logic           tog_q;
  logic [23:0]    cap_q;
  logic [2:0]     tsync_q;

  // serial clock domain: shifter and edge counter
  always_ff @(negedge sclk) begin
    if (!sync_n) sh_q <= {sh_q[SHW-2:0], sdi};
  end

  always_ff @(negedge sclk or posedge sync_n) begin
    if (sync_n)                cnt_q <= '0;
    else if (cnt_q != CNT_SAT) cnt_q <= cnt_q + 1'b1;
  end

  // frame close: capture on sync_n rise when length is exact
  always_ff @(posedge sync_n or negedge rst_n) begin
    if (!rst_n) begin
      tog_q <= 1'b0;
      cap_q <= '0;
    end else if (cnt_q == CNT_FULL) begin
      tog_q <= ~tog_q;
      cap_q <= sh_q[SHW-1:4];
    end
  end

  // system clock domain: toggle synchronizer
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) tsync_q <= '0;
    else        tsync_q <= {tsync_q[1:0], tog_q};
  end

  assign exec_o  = tsync_q[2] ^ tsync_q[1];
  assign frame_o = frame_t'(cap_q);
endmodule

// File: rtl/octdac_clrsync.sv
module octdac_clrsync (
  input  logic clk,
  input  logic clr_n,
  output logic hold_o
);
  logic [1:0] s_q;

  always_ff @(posedge clk or negedge clr_n) begin
    if (!clr_n) s_q <= 2'b11;
    else        s_q <= {s_q[0], 1'b0};
  end

  assign hold_o = s_q[1];
endmodule

// File: rtl/octdac_regs.sv
module octdac_regs
  import octdac_pkg::*;
#(
  parameter int W         = 16,
  parameter bit RESET_MID = 1'b0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             exec_i,
  input  frame_t           frame_i,
  input  logic             ld_n,
  input  logic             clr_hold_i,
  output logic [NCH*W-1:0] code_o,
  output logic [2*NCH-1:0] pd_o,
  output logic             ref_en_o,
  output logic [W-1:0]     clr_val_o
);
  localparam logic [W-1:0] CODE_ZERO = '0;
  localparam logic [W-1:0] CODE_MID  = W'(1) << (W - 1);
  localparam logic [W-1:0] CODE_FULL = '1;
  localparam logic [W-1:0] RST_CODE  = RESET_MID ? CODE_MID : CODE_ZERO;

  cmd_e         cmd;
  logic [W-1:0] code_in;
  logic         do_rst, wr_stg, upd_one, upd_all, do_pwr, do_mask, do_clrsel, do_ref;

  assign cmd     = cmd_e'(frame_i.cmd);
  assign code_in = frame_i.data[15 -: W];

  assign do_rst    = exec_i && (cmd == CMD_RESET);
  assign wr_stg    = exec_i && ((cmd == CMD_WR_STG) || (cmd == CMD_WR_UPD_ALL) ||
                                (cmd == CMD_WR_UPD_ONE));
  assign upd_one   = exec_i && ((cmd == CMD_UPD_ACT) || (cmd == CMD_WR_UPD_ONE));
  assign upd_all   = exec_i && (cmd == CMD_WR_UPD_ALL);
  assign do_pwr    = exec_i && (cmd == CMD_PWR);
  assign do_mask   = exec_i && (cmd == CMD_LD_MASK);
  assign do_clrsel = exec_i && (cmd == CMD_CLR_SEL);
  assign do_ref    = exec_i && (cmd == CMD_REF);

  // shared control state
  logic [NCH-1:0] mask_q, mask_d;
  logic [1:0]     clrsel_q, clrsel_d;
  logic           ref_q, ref_d;

  always_comb begin
    mask_d   = mask_q;
    clrsel_d = clrsel_q;
    ref_d    = ref_q;
    if (do_rst) begin
      mask_d   = '1;
      clrsel_d = 2'b00;
      ref_d    = 1'b0;
    end else begin
      if (do_mask)   mask_d   = frame_i.data[NCH-1:0];
      if (do_clrsel) clrsel_d = frame_i.data[1:0];
      if (do_ref)    ref_d    = frame_i.data[0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q   <= '1;
      clrsel_q <= 2'b00;
      ref_q    <= 1'b0;
    end else begin
      mask_q   <= mask_d;
      clrsel_q <= clrsel_d;
      ref_q    <= ref_d;
    end
  end

  always_comb begin
    case (clrsel_q)
      2'b01:   clr_val_o = CODE_MID;
      2'b10:   clr_val_o = CODE_FULL;
      default: clr_val_o = CODE_ZERO;
    endcase
  end

  assign ref_en_o = ref_q;

  // per-channel staging, active and power-down registers
  for (genvar i = 0; i < NCH; i++) begin : g_ch
    logic         sel;
    logic [W-1:0] stg_q, stg_d, act_q, act_d;
    logic [1:0]   pd_q, pd_d;

    assign sel = (frame_i.addr == 4'(i)) || (frame_i.addr == 4'hF);

    always_comb begin
      stg_d = stg_q;
      if (do_rst)            stg_d = RST_CODE;
      else if (wr_stg && sel) stg_d = code_in;

      act_d = act_q;
      if (clr_hold_i)                      act_d = clr_val_o;
      else if (do_rst)                     act_d = RST_CODE;
      else if ((upd_one && sel) || upd_all) act_d = stg_d;
      else if (!ld_n && mask_q[i])         act_d = stg_d;

      pd_d = pd_q;
      if (do_rst)                         pd_d = 2'b00;
      else if (do_pwr && frame_i.data[i]) pd_d = frame_i.data[9:8];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        stg_q <= RST_CODE;
        act_q <= RST_CODE;
        pd_q  <= 2'b00;
      end else begin
        stg_q <= stg_d;
        act_q <= act_d;
        pd_q  <= pd_d;
      end
    end

    assign code_o[i*W +: W] = clr_hold_i ? clr_val_o : act_q;
    assign pd_o[2*i +: 2]   = pd_q;
  end
endmodule

// File: rtl/octdac_ctrl.sv
module octdac_ctrl
  import octdac_pkg::*;
#(
  parameter int W         = 16,
  parameter bit RESET_MID = 1'b0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sync_n,
  input  logic             sclk,
  input  logic             sdi,
  input  logic             ld_n,
  input  logic             clr_n,
  output logic [NCH*W-1:0] code_o,
  output logic [2*NCH-1:0] pd_o,
  output logic             ref_en_o
);
  logic         exec;
  frame_t       frame;
  logic         clr_hold;
  logic [W-1:0] clr_val;

  octdac_sport u_sport (
    .clk     (clk),
    .rst_n   (rst_n),
    .sync_n  (sync_n),
    .sclk    (sclk),
    .sdi     (sdi),
    .exec_o  (exec),
    .frame_o (frame)
  );

  octdac_clrsync u_clrsync (
    .clk    (clk),
    .clr_n  (clr_n),
    .hold_o (clr_hold)
  );

  octdac_regs #(.W(W), .RESET_MID(RESET_MID)) u_regs (
    .clk        (clk),
    .rst_n      (rst_n),
    .exec_i     (exec),
    .frame_i    (frame),
    .ld_n       (ld_n),
    .clr_hold_i (clr_hold),
    .code_o     (code_o),
    .pd_o       (pd_o),
    .ref_en_o   (ref_en_o),
    .clr_val_o  (clr_val)
  );
endmodule

// File: rtl/octdac_ctrl_chk.sv
module octdac_ctrl_chk
  import octdac_pkg::*;
#(
  parameter int W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             clr_n,
  input logic             ld_n,
  input logic             clr_hold,
  input logic             exec,
  input logic [W-1:0]     clr_val,
  input logic [NCH*W-1:0] code_o,
  input logic [2*NCH-1:0] pd_o,
  input logic             ref_en_o
);
  assert_one_shot_R2: assert property (@(posedge clk) disable iff (!rst_n)
    exec |=> !exec);

  assert_code_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!exec && ld_n && !clr_hold) |=> (clr_hold || $stable(code_o)));

  assert_clr_force_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !clr_n |-> (code_o == {NCH{clr_val}}));

  assert_clr_release_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(clr_hold) |-> (code_o == {NCH{$past(clr_val)}}));

  assert_pd_stable_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !exec |=> $stable(pd_o));

  assert_ref_stable_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !exec |=> $stable(ref_en_o));
endmodule

bind octdac_ctrl octdac_ctrl_chk #(.W(W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .clr_n    (clr_n),
  .ld_n     (ld_n),
  .clr_hold (clr_hold),
  .exec     (exec),
  .clr_val  (clr_val),
  .code_o   (code_o),
  .pd_o     (pd_o),
  .ref_en_o (ref_en_o)
);

// File: tb/octdac_ctrl_bench.sv
`timescale 1ns/1ps
module octdac_ctrl_bench;
  localparam int W   = 12;
  localparam int NCH = 8;
  localparam logic [W-1:0] MID  = W'(1) << (W - 1);
  localparam logic [W-1:0] FULL = '1;

  logic clk = 1'b0;
  logic rst_n = 1'b0, sync_n = 1'b0, sclk = 1'b1, sdi = 1'b0, ld_n = 1'b1, clr_n = 1'b1;
  logic [NCH*W-1:0] code_o;
  logic [2*NCH-1:0] pd_o;
  logic             ref_en_o;

  int total = 0, bad = 0;
  bit done = 1'b0;

  logic [W-1:0] m_stg [NCH];
  logic [W-1:0] m_act [NCH];
  logic [1:0]   m_pd  [NCH];
  logic [7:0]   m_mask;
  logic [1:0]   m_clrsel;
  logic         m_ref;
  bit           m_clr;

  always #4 clk = ~clk;

  octdac_ctrl #(.W(W), .RESET_MID(1'b1)) u_octdac_ctrl (
    .clk(clk), .rst_n(rst_n), .sync_n(sync_n), .sclk(sclk), .sdi(sdi),
    .ld_n(ld_n), .clr_n(clr_n), .code_o(code_o), .pd_o(pd_o), .ref_en_o(ref_en_o)
  );

  function automatic logic [W-1:0] clr_code(input logic [1:0] s);
    if (s == 2'b01) return MID;
    if (s == 2'b10) return FULL;
    return '0;
  endfunction

  function automatic logic [W-1:0] exp_code(input int ch);
    return m_clr ? clr_code(m_clrsel) : m_act[ch];
  endfunction

  task automatic model_reset();
    for (int c = 0; c < NCH; c++) begin
      m_stg[c] = MID; m_act[c] = MID; m_pd[c] = 2'b00;
    end
    m_mask = 8'hFF; m_clrsel = 2'b00; m_ref = 1'b0;
  endtask

  task automatic model_exec(input logic [3:0] cmd, input logic [3:0] addr, input logic [15:0] data);
    logic [W-1:0] v;
    v = data[15 -: W];
    case (cmd)
      4'd0: for (int c = 0; c < NCH; c++) if (addr == 4'(c) || addr == 4'hF) m_stg[c] = v;
      4'd1: for (int c = 0; c < NCH; c++)
              if ((addr == 4'(c) || addr == 4'hF) && !m_clr) m_act[c] = m_stg[c];
      4'd2: begin
        for (int c = 0; c < NCH; c++) if (addr == 4'(c) || addr == 4'hF) m_stg[c] = v;
        if (!m_clr) for (int c = 0; c < NCH; c++) m_act[c] = m_stg[c];
      end
      4'd3: for (int c = 0; c < NCH; c++)
              if (addr == 4'(c) || addr == 4'hF) begin
                m_stg[c] = v;
                if (!m_clr) m_act[c] = v;
              end
      4'd4: for (int c = 0; c < NCH; c++) if (data[c]) m_pd[c] = data[9:8];
      4'd5: m_clrsel = data[1:0];
      4'd6: m_mask = data[7:0];
      4'd7: model_reset();
      4'd8: m_ref = data[0];
      default: ;
    endcase
  endtask

  task automatic chk(input string req, input string what, input logic [31:0] got, input logic [31:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, got, exp);
    end
  endtask

  task automatic check_all(input string req);
    @(negedge clk);
    for (int c = 0; c < NCH; c++) begin
      chk(req, $sformatf("code ch%0d", c), 32'(code_o[c*W +: W]), 32'(exp_code(c)));
      chk(req, $sformatf("pd ch%0d", c), 32'(pd_o[2*c +: 2]), 32'(m_pd[c]));
    end
    chk(req, "ref", 32'(ref_en_o), 32'(m_ref));
  endtask

  task automatic send(input logic [3:0] cmd, input logic [3:0] addr, input logic [15:0] data,
                      input int nbits, input bit apply);
    logic [31:0] w;
    w = {4'h0, cmd, addr, data, 4'h0};
    sync_n = 1'b0;
    #10;
    for (int k = 0; k < nbits; k++) begin
      sdi = (k < 32) ? w[31-k] : 1'b0;
      #10 sclk = 1'b0;
      #10 sclk = 1'b1;
    end
    #10 sync_n = 1'b1;
    repeat (8) @(posedge clk);
    if (apply && nbits == 32) model_exec(cmd, addr, data);
  endtask

  task automatic ld_pulse();
    @(negedge clk); ld_n = 1'b0;
    @(negedge clk); ld_n = 1'b1;
    if (!m_clr) for (int c = 0; c < NCH; c++) if (m_mask[c]) m_act[c] = m_stg[c];
  endtask

  task automatic clr_on();
    @(negedge clk); #1 clr_n = 1'b0; m_clr = 1'b1;
  endtask

  task automatic clr_off();
    @(negedge clk); clr_n = 1'b1;
    repeat (4) @(posedge clk);
    for (int c = 0; c < NCH; c++) m_act[c] = clr_code(m_clrsel);
    m_clr = 1'b0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog expired actual=running expected=finished");
    finish_run();
  end

  initial begin
    void'($urandom(32'h0C7A_5EED));
    m_clr = 1'b0;
    model_reset();
    #5 sync_n = 1'b1;
    repeat (5) @(posedge clk);
    #1 rst_n = 1'b1;
    repeat (4) @(posedge clk);

    check_all("R10 reset midscale");
    ld_pulse(); check_all("R10 strobe keeps reset code");

    send(4'd0, 4'd2, 16'hABC0, 32, 1); check_all("R3 staging write hidden");
    send(4'd1, 4'd2, 16'h0000, 32, 1); check_all("R1 R3 update ch2");
    send(4'd1, 4'd9, 16'h0000, 32, 1); check_all("R3 invalid address");
    send(4'd3, 4'd5, 16'h1230, 32, 1); check_all("R4 write update one");
    send(4'd0, 4'hF, 16'h7770, 32, 1); check_all("R3 broadcast staging");
    send(4'd2, 4'd0, 16'h1110, 32, 1); check_all("R4 write update all");

    send(4'd6, 4'd0, 16'h0005, 32, 1);
    send(4'd0, 4'hF, 16'h4440, 32, 1); check_all("R5 mask set");
    ld_pulse(); check_all("R5 masked strobe");

    send(4'd3, 4'hF, 16'h9990, 31, 1); check_all("R2 short frame dropped");
    send(4'd3, 4'hF, 16'h9990, 33, 1); check_all("R2 long frame dropped");

    send(4'd4, 4'd0, 16'h0381, 32, 1); check_all("R8 three-state ch0 ch7");
    send(4'd4, 4'd0, 16'h0110, 32, 1); check_all("R8 1k load ch4");
    send(4'd8, 4'd0, 16'h0001, 32, 1); check_all("R9 reference on");
    send(4'd10, 4'hF, 16'hFFFF, 32, 1); check_all("R12 unused command");

    send(4'd5, 4'd0, 16'h0002, 32, 1);
    @(negedge clk); #1 clr_n = 1'b0; m_clr = 1'b1;
    #1;
    for (int c = 0; c < NCH; c++)
      chk("R6 immediate full scale", $sformatf("code ch%0d", c), 32'(code_o[c*W +: W]), 32'(FULL));
    send(4'd3, 4'd1, 16'h2220, 32, 1); check_all("R7 active blocked");
    ld_pulse(); check_all("R7 strobe blocked");
    clr_off(); check_all("R7 release to clear code");
    send(4'd6, 4'd0, 16'h00FF, 32, 1);
    ld_pulse(); check_all("R7 staging kept");

    send(4'd5, 4'd0, 16'h0003, 32, 1);
    clr_on(); check_all("R6 code 11 zero"); clr_off(); check_all("R6 release zero");
    send(4'd5, 4'd0, 16'h0001, 32, 1);
    clr_on(); check_all("R6 midscale"); clr_off(); check_all("R6 release mid");

    send(4'd7, 4'd0, 16'h0000, 32, 1); check_all("R11 reset command");
    ld_pulse(); check_all("R11 mask restored");

    for (int n = 0; n < 160; n++) begin
      logic [3:0] cmd, addr;
      logic [15:0] data;
      int r, len;
      cmd = 4'($urandom % 12);
      r = $urandom % 10;
      addr = (r < 8) ? 4'(r) : (r == 8) ? 4'hF : 4'(8 + $urandom % 7);
      data = 16'($urandom);
      r = $urandom % 10;
      len = (r == 0) ? 31 : (r == 1) ? 33 : 32;
      send(cmd, addr, data, len, 1);
      if ($urandom % 4 == 0) ld_pulse();
      check_all("R1 R4 random mix");
    end

    finish_run();
  end
endmodule